// File: doc/BRIEF.md
# Service-Mode Hijack Controller

This block watches the bus of an 8-bit Z80-style CPU. It borrows that CPU for a separate service program, then gives it back. The host system does not notice. A service key strobe raises the non-maskable interrupt. When the CPU fetches its first opcode at the NMI vector, the controller turns on a service-mode select. That select steers the external address decoders to the service memory and I/O map.

To leave, the service code writes to a dedicated I/O port, which arms the return. The controller then waits for the CPU to read the second opcode byte of the interrupt-return instruction. At the end of that read it switches back to the host map. The return-address pops that follow therefore come from the host stack.

Out of reset the CPU runs service code from address zero, and a boot-scan flag is also set. Once service mode is released, the boot-scan flag tells the host decoder to return zero (NOP) on reads, until the host fetches its first opcode at the start of the host boot region. During boot scan, a write to the exit port releases service mode at once.

All bus strobes are active-high and are sampled on the rising clock edge. The registered outputs change on the edge after the event they respond to.

Top module: `svc_hijack_ctrl`

## Requirements
- R1: After reset, `svc_mode` is 1, `nmi_req` is 0 and `force_nop` is 0 (boot scan is set but masked by service mode).
- R2: A `svc_key` pulse while `svc_mode` is 0 and no NMI is pending sets `nmi_req` on the next clock.
- R3: A `svc_key` pulse while `svc_mode` is 1, or while `nmi_req` is already 1, leaves `nmi_req` unchanged.
- R4: Service mode is entered only by a cycle with `cpu_m1` and `cpu_mreq` at address 0x0066 while an NMI is pending. An M1 fetch at any other address leaves `svc_mode` at 0 and `nmi_req` at 1.
- R5: On the clock that detects entry, `nmi_req` drops to 0, together with `svc_mode` rising to 1.
- R6: A cycle with `cpu_iorq` and `cpu_wr` whose low 8 address bits equal 0x80 arms the exit while in service mode. The upper address bits are ignored. A write to any other port does not arm.
- R7: With the exit armed, service mode ends on the clock after the first memory read (`cpu_mreq` and `cpu_rd`) carrying data 0x45 finishes. `svc_mode` stays 1 for the whole of that read, and reads of other data values do not end it.
- R8: A 0x45 read in service mode without a prior exit-port write leaves `svc_mode` at 1.
- R9: While boot scan is set, an exit-port write clears `svc_mode` on the next clock, with no 0x45 read needed.
- R10: `force_nop` is 1 exactly when boot scan is set and `svc_mode` is 0. Boot scan clears on the first M1 fetch at 0x8000 made with `svc_mode` 0. A fetch at 0x8000 in service mode leaves it set.
- R11: Leaving service mode clears the armed state. After the next entry, a 0x45 read does not exit until the port is written again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| svc_key | input | 1 | Service key strobe |
| cpu_addr | input | 16 | CPU address bus |
| cpu_din | input | 8 | Data bus as the CPU reads it |
| cpu_m1 | input | 1 | Opcode fetch cycle, active-high |
| cpu_mreq | input | 1 | Memory request, active-high |
| cpu_iorq | input | 1 | I/O request, active-high |
| cpu_rd | input | 1 | Read strobe, active-high |
| cpu_wr | input | 1 | Write strobe, active-high |
| nmi_req | output | 1 | NMI request to the CPU |
| svc_mode | output | 1 | Selects the service map in the address decoders |
| force_nop | output | 1 | Forces host memory reads to 0x00 |

## Verification
The bench builds the block with its default parameters: a 16-bit address, an 8-bit data bus, the NMI vector at 0x0066, exit port 0x80, exit opcode 0x45 and the boot region starting at 0x8000. With those values, random fetch addresses that hit the vector, the boot boundary and the exit port often can be drawn from small biased pools. This places pre-vector M1 fetches, unarmed and armed 0x45 reads, and boot-scan port exits next to each other in many orders.

// File: rtl/svc_hijack_pkg.sv
package svc_hijack_pkg;
  localparam int unsigned ADDR_W_DEF = 16;
  localparam int unsigned DATA_W_DEF = 8;
  localparam int unsigned PORT_W_DEF = 8;
  localparam logic [15:0] NMI_VEC_DEF  = 16'h0066;
  localparam logic [15:0] BOOT_END_DEF = 16'h8000;
  localparam logic [7:0]  EXIT_PORT_DEF = 8'h80;
  localparam logic [7:0]  EXIT_OPC_DEF  = 8'h45;
endpackage

// File: rtl/svc_entry.sv
module svc_entry #(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] NMI_VEC = 'h66
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              key,
  input  logic              svc,
  input  logic              fetch,
  input  logic [ADDR_W-1:0] addr,
  output logic              nmi,
  output logic              enter
);
  logic nmi_q;

  assign enter = nmi_q & fetch & (addr == NMI_VEC);
  assign nmi   = nmi_q;

  always_ff @(posedge clk) begin
    if (rst)                        nmi_q <= 1'b0;
    else if (enter)                 nmi_q <= 1'b0;
    else if (key && !svc && !nmi_q) nmi_q <= 1'b1;
  end
endmodule

// File: rtl/svc_exit.sv
module svc_exit #(
  parameter int unsigned PORT_W = 8,
  parameter int unsigned DATA_W = 8,
  parameter logic [PORT_W-1:0] EXIT_PORT = 'h80,
  parameter logic [DATA_W-1:0] EXIT_OPC  = 'h45
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              svc,
  input  logic              boot,
  input  logic              io_wr,
  input  logic [PORT_W-1:0] port,
  input  logic              rd_act,
  input  logic [DATA_W-1:0] din,
  output logic              armed,
  output logic              exit_now
);
  logic armed_q, hit_q, rd_q, port_hit, rd_end;

  assign port_hit = svc & io_wr & (port == EXIT_PORT);
  assign rd_end   = rd_q & ~rd_act;
  assign exit_now = (port_hit & boot) | (hit_q & rd_end);
  assign armed    = armed_q;

  always_ff @(posedge clk) begin
    if (rst) rd_q <= 1'b0;
    else     rd_q <= rd_act;
  end

  always_ff @(posedge clk) begin
    if (rst || !svc || exit_now)       armed_q <= 1'b0;
    else if (port_hit && !boot)        armed_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || !svc || exit_now)                  hit_q <= 1'b0;
    else if (armed_q && rd_act && din == EXIT_OPC) hit_q <= 1'b1;
  end
endmodule

// File: rtl/svc_boot.sv
module svc_boot #(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BOOT_END = 'h8000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              svc,
  input  logic              fetch,
  input  logic [ADDR_W-1:0] addr,
  output logic              boot
);
  always_ff @(posedge clk) begin
    if (rst)                                    boot <= 1'b1;
    else if (fetch && !svc && addr == BOOT_END) boot <= 1'b0;
  end
endmodule

// File: rtl/svc_hijack_ctrl.sv
module svc_hijack_ctrl
  import svc_hijack_pkg::*;
#(
  parameter int unsigned ADDR_W = ADDR_W_DEF,
  parameter int unsigned DATA_W = DATA_W_DEF,
  parameter int unsigned PORT_W = PORT_W_DEF,
  parameter logic [ADDR_W-1:0] NMI_VEC   = NMI_VEC_DEF,
  parameter logic [ADDR_W-1:0] BOOT_END  = BOOT_END_DEF,
  parameter logic [PORT_W-1:0] EXIT_PORT = EXIT_PORT_DEF,
  parameter logic [DATA_W-1:0] EXIT_OPC  = EXIT_OPC_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              svc_key,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_din,
  input  logic              cpu_m1,
  input  logic              cpu_mreq,
  input  logic              cpu_iorq,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  output logic              nmi_req,
  output logic              svc_mode,
  output logic              force_nop
);
  logic fetch_cyc, read_cyc, io_write;
  logic enter_w, exit_w, exit_armed, boot_scan;

  assign fetch_cyc = cpu_m1 & cpu_mreq;
  assign read_cyc  = cpu_mreq & cpu_rd;
  assign io_write  = cpu_iorq & cpu_wr;

  svc_entry #(.ADDR_W(ADDR_W), .NMI_VEC(NMI_VEC)) u_entry (
    .clk(clk), .rst(rst), .key(svc_key), .svc(svc_mode),
    .fetch(fetch_cyc), .addr(cpu_addr), .nmi(nmi_req), .enter(enter_w)
  );

  svc_exit #(.PORT_W(PORT_W), .DATA_W(DATA_W),
             .EXIT_PORT(EXIT_PORT), .EXIT_OPC(EXIT_OPC)) u_exit (
    .clk(clk), .rst(rst), .svc(svc_mode), .boot(boot_scan),
    .io_wr(io_write), .port(cpu_addr[PORT_W-1:0]), .rd_act(read_cyc),
    .din(cpu_din), .armed(exit_armed), .exit_now(exit_w)
  );

  svc_boot #(.ADDR_W(ADDR_W), .BOOT_END(BOOT_END)) u_boot (
    .clk(clk), .rst(rst), .svc(svc_mode), .fetch(fetch_cyc),
    .addr(cpu_addr), .boot(boot_scan)
  );

  always_ff @(posedge clk) begin
    if (rst)          svc_mode <= 1'b1;
    else if (enter_w) svc_mode <= 1'b1;
    else if (exit_w)  svc_mode <= 1'b0;
  end

  assign force_nop = boot_scan & ~svc_mode;
endmodule

// File: rtl/svc_hijack_checker.sv
module svc_hijack_checker #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned PORT_W = 8,
  parameter logic [ADDR_W-1:0] NMI_VEC   = 'h66,
  parameter logic [ADDR_W-1:0] BOOT_END  = 'h8000,
  parameter logic [PORT_W-1:0] EXIT_PORT = 'h80
) (
  input logic              clk,
  input logic              rst,
  input logic              svc_key,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              cpu_m1,
  input logic              cpu_mreq,
  input logic              cpu_iorq,
  input logic              cpu_wr,
  input logic              nmi_req,
  input logic              svc_mode,
  input logic              armed,
  input logic              boot
);
  AST_KEY_RAISES_NMI: assert property (@(posedge clk) disable iff (rst)
    (svc_key && !svc_mode && !nmi_req) |=> nmi_req); // R2
  AST_KEY_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (svc_key && svc_mode && !nmi_req) |=> !nmi_req); // R3
  AST_NO_ENTRY_OFF_VEC: assert property (@(posedge clk) disable iff (rst)
    (!svc_mode && cpu_m1 && cpu_mreq && cpu_addr != NMI_VEC) |=> !svc_mode); // R4
  AST_ENTRY_DROPS_NMI: assert property (@(posedge clk) disable iff (rst)
    (nmi_req && cpu_m1 && cpu_mreq && cpu_addr == NMI_VEC) |=> (svc_mode && !nmi_req)); // R5
  AST_ARMED_IN_SVC: assert property (@(posedge clk) disable iff (rst)
    armed |-> svc_mode); // R11
  AST_BOOT_PORT_EXIT: assert property (@(posedge clk) disable iff (rst)
    (svc_mode && boot && cpu_iorq && cpu_wr && cpu_addr[PORT_W-1:0] == EXIT_PORT) |=> !svc_mode); // R9
  AST_BOOT_END: assert property (@(posedge clk) disable iff (rst)
    (!boot && $past(boot)) |-> $past(cpu_m1 && cpu_mreq && !svc_mode && cpu_addr == BOOT_END)); // R10
endmodule

bind svc_hijack_ctrl svc_hijack_checker #(
  .ADDR_W(ADDR_W), .PORT_W(PORT_W), .NMI_VEC(NMI_VEC),
  .BOOT_END(BOOT_END), .EXIT_PORT(EXIT_PORT)
) u_chk (
  .clk(clk), .rst(rst), .svc_key(svc_key), .cpu_addr(cpu_addr),
  .cpu_m1(cpu_m1), .cpu_mreq(cpu_mreq), .cpu_iorq(cpu_iorq), .cpu_wr(cpu_wr),
  .nmi_req(nmi_req), .svc_mode(svc_mode), .armed(exit_armed), .boot(boot_scan)
);

// File: tb/svc_hijack_ctrl_bench.sv
module svc_hijack_ctrl_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic svc_key = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_din = '0;
  logic cpu_m1 = 1'b0, cpu_mreq = 1'b0, cpu_iorq = 1'b0, cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic nmi_req, svc_mode, force_nop;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // model state
  bit m_svc, m_nmi, m_boot, m_armed;

  always #2 clk = ~clk;

  svc_hijack_ctrl u_svc_hijack_ctrl (
    .clk(clk), .rst(rst), .svc_key(svc_key), .cpu_addr(cpu_addr), .cpu_din(cpu_din),
    .cpu_m1(cpu_m1), .cpu_mreq(cpu_mreq), .cpu_iorq(cpu_iorq), .cpu_rd(cpu_rd),
    .cpu_wr(cpu_wr), .nmi_req(nmi_req), .svc_mode(svc_mode), .force_nop(force_nop)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit exp_nop(input bit boot, input bit svc);
    return boot && !svc;
  endfunction

  task automatic chk_all(input string tag);
    chk({tag, " svc_mode"}, svc_mode, m_svc);
    chk({tag, " nmi_req"}, nmi_req, m_nmi);
    chk({tag, " force_nop"}, force_nop, exp_nop(m_boot, m_svc));
  endtask

  task automatic idle();
    cpu_m1 = 0; cpu_mreq = 0; cpu_iorq = 0; cpu_rd = 0; cpu_wr = 0; svc_key = 0;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    idle(); idle();
    rst = 1'b0;
    m_svc = 1; m_nmi = 0; m_boot = 1; m_armed = 0;
  endtask

  task automatic key();
    svc_key = 1'b1;
    @(negedge clk);
    svc_key = 1'b0;
    if (!m_svc && !m_nmi) m_nmi = 1;
  endtask

  task automatic bus_read(input bit m1, input logic [15:0] a, input logic [7:0] d,
                          input bit mid_chk);
    bit was_svc = m_svc;
    cpu_addr = a; cpu_din = d; cpu_m1 = m1; cpu_mreq = 1; cpu_rd = 1;
    @(negedge clk);
    @(negedge clk);
    if (m1 && m_nmi && a == 16'h0066) begin m_svc = 1; m_nmi = 0; end
    if (mid_chk) chk("R7 held during read", svc_mode, m_svc);
    idle();
    if (m1 && !was_svc && m_boot && a == 16'h8000) m_boot = 0;
    if (was_svc && m_armed && d == 8'h45) begin m_svc = 0; m_armed = 0; end
  endtask

  task automatic io_write(input logic [15:0] a);
    cpu_addr = a; cpu_din = 8'($urandom); cpu_iorq = 1; cpu_wr = 1;
    @(negedge clk);
    @(negedge clk);
    idle();
    if (m_svc && a[7:0] == 8'h80) begin
      if (m_boot) begin m_svc = 0; m_armed = 0; end
      else m_armed = 1;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    do_reset();
    chk("R1 svc_mode", svc_mode, 1'b1);
    chk("R1 nmi_req", nmi_req, 1'b0);
    chk("R1 force_nop", force_nop, 1'b0);

    // R10: service-mode fetch at boot end does not clear boot scan
    bus_read(1, 16'h8000, 8'h00, 0);
    // R9: boot-scan port write exits at once (upper bits ignored)
    io_write(16'h3480);
    chk("R9 immediate exit", svc_mode, 1'b0);
    chk("R10 boot kept after svc fetch", force_nop, 1'b1);
    bus_read(1, 16'h7FFF, 8'h00, 0);
    chk("R10 still scanning", force_nop, 1'b1);
    bus_read(1, 16'h8000, 8'hC3, 0);
    chk("R10 cleared at boot end", force_nop, 1'b0);

    key();
    chk("R2 nmi raised", nmi_req, 1'b1);
    key();
    chk("R3 pending key ignored", nmi_req, 1'b1);
    bus_read(1, 16'h1234, 8'h00, 0);
    chk("R4 no entry off vector", svc_mode, 1'b0);
    chk("R4 nmi still pending", nmi_req, 1'b1);
    bus_read(1, 16'h0066, 8'hF5, 0);
    chk("R4 entry at vector", svc_mode, 1'b1);
    chk("R5 nmi dropped", nmi_req, 1'b0);
    key();
    chk("R3 key ignored in svc", nmi_req, 1'b0);

    bus_read(0, 16'h0200, 8'h45, 0);
    chk("R8 unarmed 0x45", svc_mode, 1'b1);
    io_write(16'h0081);
    bus_read(1, 16'h0201, 8'h45, 0);
    chk("R6 other port no arm", svc_mode, 1'b1);
    io_write(16'h1280);
    bus_read(0, 16'h0202, 8'h33, 0);
    chk("R7 other data no exit", svc_mode, 1'b1);
    bus_read(1, 16'h0203, 8'hED, 0);
    bus_read(1, 16'h0204, 8'h45, 1);
    chk("R7 exit after 0x45", svc_mode, 1'b0);
    chk("R7 host nop off", force_nop, 1'b0);

    key();
    bus_read(1, 16'h0066, 8'h00, 0);
    chk("R11 re-entered", svc_mode, 1'b1);
    bus_read(1, 16'h0300, 8'h45, 0);
    chk("R11 stale arm cleared", svc_mode, 1'b1);
    io_write(16'h0080);
    bus_read(1, 16'h0301, 8'h45, 0);
    chk("R11 fresh arm exits", svc_mode, 1'b0);

    // random mix, model-checked
    do_reset();
    chk_all("R1 re-reset");
    for (int i = 0; i < 400; i++) begin
      int op = int'($urandom_range(0, 5));
      logic [15:0] a;
      logic [7:0] d;
      case ($urandom_range(0, 3))
        0: a = 16'h0066;
        1: a = 16'h8000;
        2: a = 16'h0080 | (16'($urandom_range(0, 3)) << 8);
        default: a = 16'($urandom);
      endcase
      d = ($urandom_range(0, 2) == 0) ? 8'h45 : 8'($urandom);
      case (op)
        0: key();
        1, 2: bus_read(1, a, d, 0);
        3: bus_read(0, a, d, 0);
        default: io_write(a);
      endcase
      chk_all("RND model");
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule